// File: doc/BRIEF.md
# Heartbeat Watchdog with Emergency Close

This block watches for a supervising controller that has gone silent. Each time the controller reads the heartbeat register, a strobe reaches the block. The block counts these accesses in a wrapping 8-bit counter. It also counts whole seconds since the most recent access, from a one-pulse-per-second tick. Both counters are brought out for debug reads.

If thirty seconds pass with no access, the block raises a missing flag and forces the motor supply rails on, whatever the rail-enable register holds. It then waits one more second so the rails can settle. After that wait it issues a one-cycle emergency-close request to the motor sequencer, and it keeps a close-active level until the closed end switch engages or the sequencer reports the operation done.

A fresh access during the settle wait abandons the recovery. A cancel during the close stops it. Once the close has ended, by completion or by cancel, all further motor operations stay inhibited until a new heartbeat access arrives. That access also releases the rail override.

Top module: `hb_watchdog`

## Requirements
- R10: After reset, the access count and the idle-seconds value are 0. The missing flag, rail force, close request, close-active and motion-inhibit outputs are all 0.
- R1: Every cycle with `hb_access_i` high increments `hb_count_o` by one. The count wraps from 255 to 0.
- R2: Each `tick_1s_i` pulse increments `idle_secs_o`. A heartbeat access clears it to 0, and the clear wins over a tick in the same cycle.
- R3: `idle_secs_o` saturates at 255 and does not wrap.
- R4: In normal operation, the 30th tick since the last access raises `hb_missing_o` and `rail_force_o`. `rail_en_o` always equals `rail_en_reg_i` OR `rail_force_o`.
- R5: After the timeout, `close_req_o` pulses high for exactly one cycle on the first further tick, and `close_active_o` rises in the same cycle. Each timeout produces at most one request.
- R6: A heartbeat access during the settle wait returns the block to normal operation. It clears the missing flag and the rail force, and no close request follows.
- R7: A high `closed_sw_i` or `op_done_i` while closing ends the close. `close_active_o` falls and `motion_inhibit_o` rises, while the rail force stays on.
- R8: `cancel_i` while closing ends the close. `motion_inhibit_o` rises, and no further request is issued for that timeout.
- R9: A heartbeat access while closing does not stop the close. A heartbeat access while inhibited clears the inhibit, the rail force and the missing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_access_i | input | 1 | One-cycle strobe per heartbeat register read |
| tick_1s_i | input | 1 | One-cycle pulse once per second |
| closed_sw_i | input | 1 | Closed end switch engaged |
| cancel_i | input | 1 | Abort a running emergency close |
| op_done_i | input | 1 | Motor sequencer reports operation finished |
| rail_en_reg_i | input | 1 | Rail-enable register value |
| rail_en_o | output | 1 | Effective motor rail enable |
| rail_force_o | output | 1 | Rail override active |
| close_req_o | output | 1 | One-cycle emergency-close request |
| close_active_o | output | 1 | Emergency close in progress |
| motion_inhibit_o | output | 1 | New motor operations blocked |
| hb_missing_o | output | 1 | Heartbeat-missing flag |
| hb_count_o | output | 8 | Wrapping heartbeat access count |
| idle_secs_o | output | 8 | Seconds since last access, saturating |

## Verification
The hardest case to reach is the idle-seconds saturation. In normal operation the counter can never climb past the timeout, because the recovery sequence starts first. The bench therefore drives the block into the inhibited state after a finished close and keeps ticking there for several hundred seconds until the value pins at 255. The settle-wait abort is also narrow, because it needs an access to land after the 30th tick and before the next one; the bench places the strobe in exactly that gap.

// File: rtl/hb_wd_pkg.sv
package hb_wd_pkg;

    typedef enum logic [1:0] {
        WD_WATCH  = 2'd0,
        WD_SETTLE = 2'd1,
        WD_CLOSE  = 2'd2,
        WD_HOLD   = 2'd3
    } wd_state_e;

endpackage

// File: rtl/hb_access_counter.sv
module hb_access_counter #(
    parameter int CNT_W = 8,
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_access_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic [SEC_W-1:0] secs_o
);
    localparam logic [SEC_W-1:0] SEC_MAX = {SEC_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [SEC_W-1:0] secs;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hb_access_i) begin
            st_d.count = st_q.count + 1'b1;
            st_d.secs  = '0;
        end else if (tick_i && (st_q.secs != SEC_MAX)) begin
            st_d.secs = st_q.secs + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign secs_o  = st_q.secs;

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        hb_access_i |=> count_o == $past(count_o) + 1'b1);
    a_r2_secs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hb_access_i |=> secs_o == '0);
    a_r3_secs_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (secs_o == SEC_MAX && !hb_access_i) |=> secs_o == SEC_MAX);

endmodule

// File: rtl/hb_recovery_fsm.sv
module hb_recovery_fsm
    import hb_wd_pkg::*;
#(
    parameter int SEC_W     = 8,
    parameter int TIMEOUT_S = 30,
    parameter int SETTLE_S  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_access_i,
    input  logic             tick_i,
    input  logic [SEC_W-1:0] secs_i,
    input  logic             closed_sw_i,
    input  logic             cancel_i,
    input  logic             op_done_i,
    output logic             force_o,
    output logic             missing_o,
    output logic             req_o,
    output logic             closing_o,
    output logic             inhibit_o
);
    localparam int                ST_W      = $clog2(SETTLE_S + 1);
    localparam logic [SEC_W-1:0]  SECS_LAST = SEC_W'(TIMEOUT_S - 1);
    localparam logic [ST_W-1:0]   SET_LAST  = ST_W'(SETTLE_S - 1);

    typedef struct packed {
        wd_state_e       state;
        logic [ST_W-1:0] settle;
        logic            force_on;
        logic            missing;
        logic            req;
    } fsm_state_t;

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        unique case (st_q.state)
            WD_WATCH: begin
                if (!hb_access_i && tick_i && secs_i == SECS_LAST) begin
                    st_d.state    = WD_SETTLE;
                    st_d.settle   = '0;
                    st_d.force_on = 1'b1;
                    st_d.missing  = 1'b1;
                end
            end
            WD_SETTLE: begin
                if (hb_access_i) begin
                    st_d.state    = WD_WATCH;
                    st_d.force_on = 1'b0;
                    st_d.missing  = 1'b0;
                end else if (tick_i) begin
                    if (st_q.settle == SET_LAST) begin
                        st_d.state = WD_CLOSE;
                        st_d.req   = 1'b1;
                    end else begin
                        st_d.settle = st_q.settle + 1'b1;
                    end
                end
            end
            WD_CLOSE: begin
                if (cancel_i || closed_sw_i || op_done_i) begin
                    st_d.state = WD_HOLD;
                end
            end
            WD_HOLD: begin
                if (hb_access_i) begin
                    st_d.state    = WD_WATCH;
                    st_d.force_on = 1'b0;
                    st_d.missing  = 1'b0;
                end
            end
            default: st_d.state = WD_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= WD_WATCH;
        end else begin
            st_q <= st_d;
        end
    end

    assign force_o   = st_q.force_on;
    assign missing_o = st_q.missing;
    assign req_o     = st_q.req;
    assign closing_o = (st_q.state == WD_CLOSE);
    assign inhibit_o = (st_q.state == WD_HOLD);

    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    a_r5_req_enters_close: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> closing_o && force_o);
    a_r4_missing_forces: assert property (@(posedge clk) disable iff (!rst_n)
        missing_o |-> force_o);
    a_r8_cancel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (closing_o && cancel_i) |=> inhibit_o && !closing_o);
    a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_o && hb_access_i) |=> !inhibit_o && !force_o);

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog
    import hb_wd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SEC_W     = 8,
    parameter int TIMEOUT_S = 30,
    parameter int SETTLE_S  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_access_i,
    input  logic             tick_1s_i,
    input  logic             closed_sw_i,
    input  logic             cancel_i,
    input  logic             op_done_i,
    input  logic             rail_en_reg_i,
    output logic             rail_en_o,
    output logic             rail_force_o,
    output logic             close_req_o,
    output logic             close_active_o,
    output logic             motion_inhibit_o,
    output logic             hb_missing_o,
    output logic [CNT_W-1:0] hb_count_o,
    output logic [SEC_W-1:0] idle_secs_o
);
    logic [SEC_W-1:0] secs_w;

    hb_access_counter #(
        .CNT_W (CNT_W),
        .SEC_W (SEC_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .hb_access_i (hb_access_i),
        .tick_i      (tick_1s_i),
        .count_o     (hb_count_o),
        .secs_o      (secs_w)
    );

    hb_recovery_fsm #(
        .SEC_W     (SEC_W),
        .TIMEOUT_S (TIMEOUT_S),
        .SETTLE_S  (SETTLE_S)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hb_access_i (hb_access_i),
        .tick_i      (tick_1s_i),
        .secs_i      (secs_w),
        .closed_sw_i (closed_sw_i),
        .cancel_i    (cancel_i),
        .op_done_i   (op_done_i),
        .force_o     (rail_force_o),
        .missing_o   (hb_missing_o),
        .req_o       (close_req_o),
        .closing_o   (close_active_o),
        .inhibit_o   (motion_inhibit_o)
    );

    assign idle_secs_o = secs_w;
    assign rail_en_o   = rail_en_reg_i | rail_force_o;

    a_r4_rails_on_when_forced: assert property (@(posedge clk) disable iff (!rst_n)
        rail_force_o |-> rail_en_o);
    a_r7_done_ends_close: assert property (@(posedge clk) disable iff (!rst_n)
        (close_active_o && (closed_sw_i || op_done_i)) |=> motion_inhibit_o && rail_force_o);

endmodule

// File: tb/hb_watchdog_tb_top.sv
module hb_watchdog_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hb_access_i = 1'b0, tick_1s_i = 1'b0, closed_sw_i = 1'b0;
    logic       cancel_i = 1'b0, op_done_i = 1'b0, rail_en_reg_i = 1'b0;
    logic       rail_en_o, rail_force_o, close_req_o, close_active_o;
    logic       motion_inhibit_o, hb_missing_o;
    logic [7:0] hb_count_o, idle_secs_o;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    hb_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .hb_access_i(hb_access_i), .tick_1s_i(tick_1s_i),
        .closed_sw_i(closed_sw_i), .cancel_i(cancel_i), .op_done_i(op_done_i),
        .rail_en_reg_i(rail_en_reg_i), .rail_en_o(rail_en_o), .rail_force_o(rail_force_o),
        .close_req_o(close_req_o), .close_active_o(close_active_o),
        .motion_inhibit_o(motion_inhibit_o), .hb_missing_o(hb_missing_o),
        .hb_count_o(hb_count_o), .idle_secs_o(idle_secs_o)
    );

    always @(negedge clk) if (rst_n && close_req_o) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        hb_access_i = 1'b0; tick_1s_i = 1'b0; closed_sw_i = 1'b0;
        cancel_i = 1'b0; op_done_i = 1'b0;
    endtask

    task automatic access();
        hb_access_i = 1'b1; step(); exp_cnt = (exp_cnt + 1) % 256;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1s_i = 1'b1; step(); step();
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        chk("R10 count", hb_count_o, 0);
        chk("R10 secs", idle_secs_o, 0);
        chk("R10 force", rail_force_o, 0);
        chk("R10 missing", hb_missing_o, 0);
        chk("R10 req", close_req_o, 0);
        chk("R10 active", close_active_o, 0);
        chk("R10 inhibit", motion_inhibit_o, 0);

        // R1 wrap sweep
        for (int i = 1; i <= 300; i++) begin
            access();
            chk("R1 count", hb_count_o, exp_cnt);
        end

        // R2 counting and access priority
        ticks(5);
        chk("R2 secs after 5", idle_secs_o, 5);
        hb_access_i = 1'b1; tick_1s_i = 1'b1; step(); exp_cnt = (exp_cnt + 1) % 256;
        chk("R2 clear wins", idle_secs_o, 0);
        chk("R1 count w/ tick", hb_count_o, exp_cnt);

        // R4 timeout
        ticks(29);
        chk("R2 secs 29", idle_secs_o, 29);
        chk("R4 no missing yet", hb_missing_o, 0);
        rail_en_reg_i = 1'b1; #1;
        chk("R4 rail passthrough", rail_en_o, 1);
        rail_en_reg_i = 1'b0; #1;
        chk("R4 rail off", rail_en_o, 0);
        tick_1s_i = 1'b1; step();
        chk("R4 missing", hb_missing_o, 1);
        chk("R4 force", rail_force_o, 1);
        chk("R4 rail forced", rail_en_o, 1);
        chk("R5 no early active", close_active_o, 0);

        // R5 settle then single request
        repeat (10) step();
        chk("R5 no req before tick", pulses, 0);
        tick_1s_i = 1'b1; step();
        chk("R5 req high", close_req_o, 1);
        chk("R5 active", close_active_o, 1);
        step();
        chk("R5 req one cycle", close_req_o, 0);
        chk("R5 pulse count", pulses, 1);

        // R9 access while closing does not stop it
        access();
        chk("R9 still closing", close_active_o, 1);
        chk("R9 still missing", hb_missing_o, 1);

        // R7 closed switch ends close
        closed_sw_i = 1'b1; step();
        chk("R7 inactive", close_active_o, 0);
        chk("R7 inhibit", motion_inhibit_o, 1);
        chk("R7 force kept", rail_force_o, 1);

        // R3 saturation while held
        ticks(300);
        chk("R3 saturate", idle_secs_o, 255);
        chk("R5 one req per timeout", pulses, 1);

        // R9 release
        access();
        chk("R9 inhibit cleared", motion_inhibit_o, 0);
        chk("R9 force cleared", rail_force_o, 0);
        chk("R9 missing cleared", hb_missing_o, 0);
        chk("R2 secs cleared", idle_secs_o, 0);

        // R6 abort in settle
        ticks(30);
        chk("R6 in settle", rail_force_o, 1);
        access();
        chk("R6 force off", rail_force_o, 0);
        chk("R6 missing off", hb_missing_o, 0);
        ticks(5);
        chk("R6 no req", pulses, 1);
        chk("R6 normal counting", idle_secs_o, 5);

        // R8 cancel
        access();
        ticks(31);
        chk("R8 closing", close_active_o, 1);
        p0 = pulses;
        cancel_i = 1'b1; step();
        chk("R8 inhibit", motion_inhibit_o, 1);
        chk("R8 inactive", close_active_o, 0);
        ticks(3);
        chk("R8 no more req", pulses, p0);

        // R7 operation done
        access();
        ticks(31);
        chk("R7 closing again", close_active_o, 1);
        op_done_i = 1'b1; step();
        chk("R7 done inhibit", motion_inhibit_o, 1);
        chk("R7 done inactive", close_active_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule